// File: doc/BRIEF.md
# Operand Effective Address Generator

This block works out where the operand of an instruction lives for an 8-bit accumulator CPU with a 16-bit address space. The decode stage hands it a small mode code, the one or two bytes that follow the opcode, the current index register pair (called HX here), the stack pointer and the address of the instruction's first byte. The decode stage also supplies a branch-condition flag. One clock later the block returns the effective address, a flag marking the result as an immediate value rather than an address, the instruction's total length in bytes, the value the index register should take next and the address of the next instruction.

Mode codes on `req_mode`: 0 inherent, 1 immediate byte, 2 immediate word, 3 page-zero direct, 4 extended, 5 indexed with no offset, 6 indexed with 8-bit offset, 7 indexed with 16-bit offset, 8 stack with 8-bit offset, 9 stack with 16-bit offset, 10 indexed with post-increment, 11 indexed with 8-bit offset and post-increment, 12 relative branch. Codes 13 to 15 are reserved. `req_byte1` is the first byte after the opcode and `req_byte2` the second. A 16-bit value carried in those bytes puts the high byte first. `req_pc` points at the first byte of the instruction, which is the prefix byte for the stack forms. All sums are taken modulo 65536.

The block does not decode opcodes, evaluate branch conditions or run bus cycles. Each request held with `req_valid` high on a rising edge produces exactly one result on the next edge.

Top module: `oper_ea_gen`

## Requirements
- R1: After reset `res_valid` is 0. A request sampled with `req_valid` high yields `res_valid` high on the following cycle only, and a cycle without a request yields `res_valid` low.
- R2: Mode 3 gives the address {0x00, byte1} with length 2, so the result always lies in 0x0000 to 0x00FF.
- R3: Mode 4 gives the address {byte1, byte2} with length 3.
- R4: Modes 5, 6 and 7 give HX, HX + byte1 and HX + {byte1, byte2}. The offsets are unsigned and the sums wrap at 16 bits. The lengths are 1, 2 and 3, and `res_hx` equals the input HX.
- R5: Modes 8 and 9 give SP + byte1 and SP + {byte1, byte2}, both unsigned and wrapping. The lengths are 3 and 4 because the prefix byte counts. `res_hx` equals the input HX.
- R6: Modes 10 and 11 give HX and HX + byte1 as the address, with lengths 1 and 2. `res_hx` is the input HX plus 1 and wraps from 0xFFFF to 0x0000.
- R7: Mode 12 has length 2 and its address is PC + 2 + byte1 taken as a signed value. When `req_cond` is 1, `res_pc` is that address; when it is 0, `res_pc` is PC + 2.
- R8: Modes 1 and 2 set `res_imm` and return the value {0x00, byte1} (length 2) or {byte1, byte2} (length 3) on `res_ea`. Every other mode clears `res_imm`.
- R9: Mode 0 and the reserved codes 13 to 15 give address 0, length 1 and an unchanged HX.
- R10: For every mode except 12, `res_pc` is PC + length, wrapping at 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 4 | Addressing mode code |
| req_byte1 | input | 8 | First byte after the opcode |
| req_byte2 | input | 8 | Second byte after the opcode |
| req_hx | input | 16 | Current index register pair |
| req_sp | input | 16 | Current stack pointer |
| req_pc | input | 16 | Address of the instruction's first byte |
| req_cond | input | 1 | Branch condition result for mode 12 |
| res_valid | output | 1 | Result present this cycle |
| res_ea | output | 16 | Effective address, or immediate value when res_imm is 1 |
| res_imm | output | 1 | Result is an immediate value |
| res_len | output | 3 | Instruction length in bytes |
| res_hx | output | 16 | Index register value after the instruction |
| res_pc | output | 16 | Address of the next instruction |

## Verification
The bench targets the carries that must be dropped. A 16-bit offset added to an HX near 0xFFFF, a post-increment from 0xFFFF, a branch forward across 0xFFFF and a fall-through past the top of memory each have an exact expected value. A design that widened the sum or saturated it would report a different result. Negative branch offsets such as 0xAE catch a design that zero-extends the displacement, because its target would jump forward instead of back. Page-zero direct requests with a non-zero second byte catch a design that lets that byte into the upper half of the address. Stack requests are checked for length 3 and 4 against indexed requests of the same offset, which exposes a design that forgets the prefix byte. The reserved codes are checked to show that none of them moves HX.

// File: rtl/oeag_pkg.sv
package oeag_pkg;

   typedef enum logic [3:0] {
      M_INH   = 4'd0,
      M_IMM8  = 4'd1,
      M_IMM16 = 4'd2,
      M_DIR   = 4'd3,
      M_EXT   = 4'd4,
      M_IX0   = 4'd5,
      M_IX8   = 4'd6,
      M_IX16  = 4'd7,
      M_SP8   = 4'd8,
      M_SP16  = 4'd9,
      M_IXP   = 4'd10,
      M_IX8P  = 4'd11,
      M_REL   = 4'd12
   } mode_e;

   localparam int MODE_W = 4;

   function automatic logic is_postinc(input logic [MODE_W-1:0] m);
      return (m == M_IXP) || (m == M_IX8P);
   endfunction

endpackage

// File: rtl/oeag_len.sv
module oeag_len
   import oeag_pkg::*;
#(
   parameter int LENW      = 3,
   parameter int SP_PREFIX = 1
) (
   input  logic [MODE_W-1:0] mode,
   output logic [LENW-1:0]   len
);

   localparam logic [LENW-1:0] L1    = LENW'(1);
   localparam logic [LENW-1:0] L2    = LENW'(2);
   localparam logic [LENW-1:0] L3    = LENW'(3);
   localparam logic [LENW-1:0] L_SP8 = LENW'(2 + SP_PREFIX);
   localparam logic [LENW-1:0] L_SP16 = LENW'(3 + SP_PREFIX);

   always_comb begin
      case (mode_e'(mode))
         M_IMM8, M_DIR, M_IX8, M_IX8P, M_REL: len = L2;
         M_IMM16, M_EXT, M_IX16:              len = L3;
         M_SP8:                               len = L_SP8;
         M_SP16:                              len = L_SP16;
         default:                             len = L1;
      endcase
   end

endmodule

// File: rtl/oeag_addr.sv
module oeag_addr
   import oeag_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic [MODE_W-1:0] mode,
   input  logic [DW-1:0]     byte1,
   input  logic [DW-1:0]     byte2,
   input  logic [AW-1:0]     hx,
   input  logic [AW-1:0]     sp,
   input  logic [AW-1:0]     pc,
   output logic [AW-1:0]     ea,
   output logic              imm
);

   localparam int HW = AW - DW;

   logic [AW-1:0] off_short;
   logic [AW-1:0] off_long;
   logic [AW-1:0] off_signed;
   logic [AW-1:0] base;
   logic [AW-1:0] offset;
   logic          use_sum;

   assign off_short  = {{HW{1'b0}}, byte1};
   assign off_long   = {byte1, byte2};
   assign off_signed = {{HW{byte1[DW-1]}}, byte1};

   always_comb begin
      base    = '0;
      offset  = '0;
      use_sum = 1'b0;
      imm     = 1'b0;
      case (mode_e'(mode))
         M_IMM8:  begin imm = 1'b1; offset = off_short; end
         M_IMM16: begin imm = 1'b1; offset = off_long;  end
         M_DIR:   offset = off_short;
         M_EXT:   offset = off_long;
         M_IX0, M_IXP: base = hx;
         M_IX8, M_IX8P: begin base = hx; offset = off_short; use_sum = 1'b1; end
         M_IX16:  begin base = hx; offset = off_long;  use_sum = 1'b1; end
         M_SP8:   begin base = sp; offset = off_short; use_sum = 1'b1; end
         M_SP16:  begin base = sp; offset = off_long;  use_sum = 1'b1; end
         M_REL:   begin base = pc + AW'(2); offset = off_signed; use_sum = 1'b1; end
         default: ;
      endcase
   end

   // one shared adder; modes without a sum pass base or offset alone
   always_comb begin
      if (use_sum) ea = base + offset;
      else         ea = base | offset;
   end

endmodule

// File: rtl/oeag_flow.sv
module oeag_flow
   import oeag_pkg::*;
#(
   parameter int AW   = 16,
   parameter int LENW = 3
) (
   input  logic [MODE_W-1:0] mode,
   input  logic [LENW-1:0]   len,
   input  logic [AW-1:0]     ea,
   input  logic [AW-1:0]     hx,
   input  logic [AW-1:0]     pc,
   input  logic              cond,
   output logic [AW-1:0]     hx_next,
   output logic [AW-1:0]     pc_next
);

   logic [AW-1:0] pc_seq;
   logic          taken;

   assign pc_seq  = pc + AW'(len);
   assign taken   = (mode == M_REL) && cond;
   assign pc_next = taken ? ea : pc_seq;
   assign hx_next = is_postinc(mode) ? hx + AW'(1) : hx;

endmodule

// File: rtl/oper_ea_gen.sv
module oper_ea_gen
   import oeag_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 8,
   parameter int LENW      = 3,
   parameter int SP_PREFIX = 1,
   parameter int OUT_STAGE = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [3:0]      req_mode,
   input  logic [DW-1:0]   req_byte1,
   input  logic [DW-1:0]   req_byte2,
   input  logic [AW-1:0]   req_hx,
   input  logic [AW-1:0]   req_sp,
   input  logic [AW-1:0]   req_pc,
   input  logic            req_cond,
   output logic            res_valid,
   output logic [AW-1:0]   res_ea,
   output logic            res_imm,
   output logic [LENW-1:0] res_len,
   output logic [AW-1:0]   res_hx,
   output logic [AW-1:0]   res_pc
);

   if (AW != 2 * DW) begin : g_bad_width
      $error("oper_ea_gen: AW must be twice DW");
   end
   if (LENW < 3 || (2 ** LENW) <= 3 + SP_PREFIX) begin : g_bad_lenw
      $error("oper_ea_gen: LENW too narrow for the longest instruction");
   end
   if (SP_PREFIX < 0 || SP_PREFIX > 2) begin : g_bad_prefix
      $error("oper_ea_gen: SP_PREFIX must be 0 to 2");
   end
   if (OUT_STAGE != 0 && OUT_STAGE != 1) begin : g_bad_stage
      $error("oper_ea_gen: OUT_STAGE must be 0 or 1");
   end

   logic [AW-1:0]   c_ea;
   logic            c_imm;
   logic [LENW-1:0] c_len;
   logic [AW-1:0]   c_hx;
   logic [AW-1:0]   c_pc;

   oeag_len #(.LENW(LENW), .SP_PREFIX(SP_PREFIX)) u_len (
      .mode (req_mode),
      .len  (c_len)
   );

   oeag_addr #(.AW(AW), .DW(DW)) u_addr (
      .mode  (req_mode),
      .byte1 (req_byte1),
      .byte2 (req_byte2),
      .hx    (req_hx),
      .sp    (req_sp),
      .pc    (req_pc),
      .ea    (c_ea),
      .imm   (c_imm)
   );

   oeag_flow #(.AW(AW), .LENW(LENW)) u_flow (
      .mode    (req_mode),
      .len     (c_len),
      .ea      (c_ea),
      .hx      (req_hx),
      .pc      (req_pc),
      .cond    (req_cond),
      .hx_next (c_hx),
      .pc_next (c_pc)
   );

   if (OUT_STAGE == 1) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            res_valid <= 1'b0;
            res_ea    <= '0;
            res_imm   <= 1'b0;
            res_len   <= '0;
            res_hx    <= '0;
            res_pc    <= '0;
         end else begin
            res_valid <= req_valid;
            if (req_valid) begin
               res_ea  <= c_ea;
               res_imm <= c_imm;
               res_len <= c_len;
               res_hx  <= c_hx;
               res_pc  <= c_pc;
            end
         end
      end
   end else begin : g_comb
      assign res_valid = req_valid & rst_n;
      assign res_ea    = c_ea;
      assign res_imm   = c_imm;
      assign res_len   = c_len;
      assign res_hx    = c_hx;
      assign res_pc    = c_pc;
   end

endmodule

// File: rtl/oeag_chk.sv
module oeag_chk
   import oeag_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 8,
   parameter int LENW      = 3,
   parameter int OUT_STAGE = 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic [3:0]      req_mode,
   input logic [DW-1:0]   req_byte1,
   input logic [AW-1:0]   req_hx,
   input logic [AW-1:0]   req_pc,
   input logic            req_cond,
   input logic            res_valid,
   input logic [AW-1:0]   res_ea,
   input logic            res_imm,
   input logic [LENW-1:0] res_len,
   input logic [AW-1:0]   res_hx,
   input logic [AW-1:0]   res_pc
);

   if (OUT_STAGE == 1) begin : g_seq
      // R1
      a_r1_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> res_valid);
      a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid |=> !res_valid);
      // R2
      a_r2_page_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_mode == M_DIR) |=>
            (res_ea[AW-1:DW] == '0) && (res_ea[DW-1:0] == $past(req_byte1)));
      // R4
      a_r4_hx_kept: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_mode != M_IXP && req_mode != M_IX8P) |=>
            res_hx == $past(req_hx));
      // R5
      a_r5_sp_prefix_len: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && (req_mode == M_SP8 || req_mode == M_SP16)) |=>
            res_len >= LENW'(3));
      // R6
      a_r6_postinc: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && (req_mode == M_IXP || req_mode == M_IX8P)) |=>
            res_hx == AW'($past(req_hx) + AW'(1)));
      // R7
      a_r7_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_mode == M_REL && !req_cond) |=>
            res_pc == AW'($past(req_pc) + AW'(2)));
      // R8
      a_r8_imm_flag: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=>
            res_imm == ($past(req_mode) == M_IMM8 || $past(req_mode) == M_IMM16));
      // R10
      a_r10_pc_advance: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_mode != M_REL) |=>
            res_pc == AW'($past(req_pc) + AW'(res_len)));
   end else begin : g_none
      a_r1_comb_valid: assert property (@(posedge clk) disable iff (!rst_n)
         res_valid == req_valid);
   end

endmodule

bind oper_ea_gen oeag_chk #(
   .AW(AW), .DW(DW), .LENW(LENW), .OUT_STAGE(OUT_STAGE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_mode  (req_mode),
   .req_byte1 (req_byte1),
   .req_hx    (req_hx),
   .req_pc    (req_pc),
   .req_cond  (req_cond),
   .res_valid (res_valid),
   .res_ea    (res_ea),
   .res_imm   (res_imm),
   .res_len   (res_len),
   .res_hx    (res_hx),
   .res_pc    (res_pc)
);

// File: tb/oper_ea_gen_tb.sv
`timescale 1ns/1ps
module oper_ea_gen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_mode = '0;
   logic [7:0]  req_byte1 = '0;
   logic [7:0]  req_byte2 = '0;
   logic [15:0] req_hx = '0;
   logic [15:0] req_sp = '0;
   logic [15:0] req_pc = '0;
   logic        req_cond = 1'b0;
   logic        res_valid;
   logic [15:0] res_ea;
   logic        res_imm;
   logic [2:0]  res_len;
   logic [15:0] res_hx;
   logic [15:0] res_pc;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   typedef struct {
      logic [15:0] ea;
      logic        imm;
      logic [2:0]  len;
      logic [15:0] hx;
      logic [15:0] pc;
      string       tag;
   } exp_t;

   exp_t sb[$];

   always #2.5 clk = ~clk;

   oper_ea_gen u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .req_byte1(req_byte1), .req_byte2(req_byte2), .req_hx(req_hx),
      .req_sp(req_sp), .req_pc(req_pc), .req_cond(req_cond),
      .res_valid(res_valid), .res_ea(res_ea), .res_imm(res_imm),
      .res_len(res_len), .res_hx(res_hx), .res_pc(res_pc)
   );

   function automatic exp_t model(input logic [3:0] m, input logic [7:0] b1,
                                  input logic [7:0] b2, input logic [15:0] hx,
                                  input logic [15:0] sp, input logic [15:0] pc,
                                  input logic c, input string tag);
      exp_t e;
      logic [15:0] tgt;
      e.tag = tag; e.imm = 1'b0; e.hx = hx; e.ea = 16'h0000; e.len = 3'd1;
      case (m)
         4'd1:  begin e.ea = {8'h00, b1}; e.imm = 1'b1; e.len = 3'd2; end
         4'd2:  begin e.ea = {b1, b2};    e.imm = 1'b1; e.len = 3'd3; end
         4'd3:  begin e.ea = {8'h00, b1}; e.len = 3'd2; end
         4'd4:  begin e.ea = {b1, b2};    e.len = 3'd3; end
         4'd5:  begin e.ea = hx;          e.len = 3'd1; end
         4'd6:  begin e.ea = 16'(hx + {8'h00, b1}); e.len = 3'd2; end
         4'd7:  begin e.ea = 16'(hx + {b1, b2});    e.len = 3'd3; end
         4'd8:  begin e.ea = 16'(sp + {8'h00, b1}); e.len = 3'd3; end
         4'd9:  begin e.ea = 16'(sp + {b1, b2});    e.len = 3'd4; end
         4'd10: begin e.ea = hx; e.hx = 16'(hx + 16'd1); e.len = 3'd1; end
         4'd11: begin e.ea = 16'(hx + {8'h00, b1}); e.hx = 16'(hx + 16'd1); e.len = 3'd2; end
         4'd12: e.len = 3'd2;
         default: ;
      endcase
      e.pc = 16'(pc + {13'd0, e.len});
      if (m == 4'd12) begin
         tgt  = 16'(pc + 16'd2 + {{8{b1[7]}}, b1});
         e.ea = tgt;
         if (c) e.pc = tgt;
      end
      return e;
   endfunction

   task automatic send(input logic [3:0] m, input logic [7:0] b1, input logic [7:0] b2,
                       input logic [15:0] hx, input logic [15:0] sp, input logic [15:0] pc,
                       input logic c, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_mode = m; req_byte1 = b1; req_byte2 = b2;
      req_hx = hx; req_sp = sp; req_pc = pc; req_cond = c;
      sb.push_back(model(m, b1, b2, hx, sp, pc, c, tag));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !done && res_valid) begin
         tests++;
         if (sb.size() == 0) begin
            fails++;
            $display("FAIL R1 unexpected result: got valid=1 expected valid=0");
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (res_ea !== e.ea || res_imm !== e.imm || res_len !== e.len ||
                res_hx !== e.hx || res_pc !== e.pc) begin
               fails++;
               $display("FAIL %s: got ea=%h imm=%b len=%0d hx=%h pc=%h expected ea=%h imm=%b len=%0d hx=%h pc=%h",
                        e.tag, res_ea, res_imm, res_len, res_hx, res_pc,
                        e.ea, e.imm, e.len, e.hx, e.pc);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R1 watchdog: got hung run expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      tests++;   // R1 reset state
      if (res_valid !== 1'b0 || res_ea !== 16'h0000) begin
         fails++;
         $display("FAIL R1 reset: got valid=%b ea=%h expected valid=0 ea=0000", res_valid, res_ea);
      end
      @(negedge clk); rst_n = 1'b1;
      idle(2);

      send(4'd3,  8'h50, 8'hC3, 16'h1234, 16'h00D0, 16'h2000, 1'b0, "R2 direct");
      send(4'd3,  8'hFF, 8'hFF, 16'hFFFF, 16'h00D0, 16'h2002, 1'b0, "R2 direct top");
      send(4'd4,  8'h04, 8'h00, 16'h1234, 16'h00D0, 16'h2004, 1'b0, "R3 extended");
      send(4'd4,  8'hAB, 8'hCD, 16'h1234, 16'h00D0, 16'hFFFE, 1'b0, "R10 extended pc wrap");
      send(4'd5,  8'h77, 8'h66, 16'h0400, 16'h00D0, 16'h3000, 1'b0, "R4 indexed no offset");
      send(4'd6,  8'h0A, 8'h00, 16'h0400, 16'h00D0, 16'h3001, 1'b0, "R4 indexed 8-bit");
      send(4'd7,  8'h01, 8'h00, 16'h0050, 16'h00D0, 16'h3003, 1'b0, "R4 indexed 16-bit");
      send(4'd7,  8'h00, 8'h20, 16'hFFF0, 16'h00D0, 16'h3006, 1'b0, "R4 indexed 16-bit wrap");
      send(4'd6,  8'hFF, 8'h00, 16'hFFFF, 16'h00D0, 16'h3009, 1'b0, "R4 indexed 8-bit wrap");
      idle(1);
      send(4'd8,  8'h05, 8'h11, 16'h4444, 16'h00D0, 16'h4000, 1'b0, "R5 stack 8-bit");
      send(4'd9,  8'h01, 8'h00, 16'h4444, 16'h00D0, 16'h4003, 1'b0, "R5 stack 16-bit");
      send(4'd9,  8'hFF, 8'h40, 16'h4444, 16'h00D0, 16'h4007, 1'b0, "R5 stack 16-bit wrap");
      send(4'd10, 8'h00, 8'h00, 16'h0400, 16'h00D0, 16'h5000, 1'b0, "R6 post-increment");
      send(4'd10, 8'h99, 8'h00, 16'hFFFF, 16'h00D0, 16'h5001, 1'b0, "R6 post-increment wrap");
      send(4'd11, 8'h50, 8'h00, 16'h0400, 16'h00D0, 16'h5002, 1'b0, "R6 offset post-increment");
      send(4'd11, 8'h10, 8'h00, 16'hFFFF, 16'h00D0, 16'h5004, 1'b0, "R6 offset post-increment wrap");
      idle(2);
      send(4'd12, 8'hAE, 8'h00, 16'h1111, 16'h00D0, 16'h8150, 1'b1, "R7 branch back taken");
      send(4'd12, 8'hAE, 8'h00, 16'h1111, 16'h00D0, 16'h8150, 1'b0, "R7 branch not taken");
      send(4'd12, 8'h10, 8'h00, 16'h1111, 16'h00D0, 16'h8000, 1'b1, "R7 branch forward");
      send(4'd12, 8'h05, 8'h00, 16'h1111, 16'h00D0, 16'hFFFE, 1'b1, "R7 branch wrap");
      send(4'd12, 8'h80, 8'h00, 16'h1111, 16'h00D0, 16'h0010, 1'b1, "R7 branch most negative");
      send(4'd1,  8'hFF, 8'h12, 16'h1111, 16'h00D0, 16'h6000, 1'b0, "R8 immediate byte");
      send(4'd2,  8'h12, 8'h34, 16'h1111, 16'h00D0, 16'h6002, 1'b0, "R8 immediate word");
      send(4'd0,  8'h5A, 8'hA5, 16'h2222, 16'h00D0, 16'h7000, 1'b1, "R9 inherent");
      send(4'd13, 8'h5A, 8'hA5, 16'hFFFF, 16'h00D0, 16'h7001, 1'b1, "R9 reserved 13");
      send(4'd15, 8'h01, 8'h02, 16'h0400, 16'h00D0, 16'hFFFF, 1'b1, "R9 reserved 15 pc wrap");
      idle(4);

      tests++;   // R1 every request answered once
      if (sb.size() != 0) begin
         fails++;
         $display("FAIL R1 missing results: got %0d pending expected 0", sb.size());
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule